// File: doc/BRIEF.md
# I/Q Polar Converter with Phase-Difference Frequency Output

This block accepts a stream of signed baseband in-phase (I) and quadrature (Q) sample pairs, each qualified by a valid strobe. For every accepted pair it returns the vector length, the vector angle and the change in angle since the previous accepted pair. The angle change is the instantaneous frequency. Automatic frequency control loops and simple AM, FM, FSK and DPSK demodulators can use it directly. A following smoothing filter is expected but is not part of this block.

One shared pipeline produces all three results. A pre-rotation stage folds left-half-plane vectors into the right half plane. A chain of shift-and-add vectoring stages (CORDIC) drives the vector onto the positive I axis and accumulates the angle. A gain stage removes the CORDIC growth from the length with a constant multiply and rounds the angle. An output stage forms the frequency word, and a two-state machine controls that stage:

- `DS_NOPREV` is the state after reset. No earlier angle exists in this state.
- `DS_PRIMED` is the state once an angle has been delivered.
- Transition `NOPREV→PRIMED` fires on the first valid sample to reach the output stage. That sample gets a frequency of zero.
- Transition `PRIMED→PRIMED` holds on every later cycle. Each valid sample then gets its angle minus the angle held from the previous valid sample.

A separate shift register carries the input strobe alongside the data pipeline and forms the output strobe.

Top module: `iq_polar_disc`

## Requirements
- R1: `out_mag` is the unsigned rounded value of sqrt(I²+Q²) for the sample pair, within ±4 LSB.
- R2: `out_phase` is the four-quadrant arctangent of Q/I as an unsigned binary angle, where 65536 is one full turn. The +I axis reads 0, the +Q axis reads 16384, the −I axis reads 32768 and the −Q axis reads 49152. Accuracy is ±8 LSB.
- R3: Pairs with negative I (second and third quadrants) produce angles between 16384 and 49152 that are correct to the same ±8 LSB.
- R4: For every valid output after the first, `out_freq` equals (`out_phase` − previous valid `out_phase`) modulo 65536. It is exact and wraps across the 0/65535 boundary.
- R5: The first valid output after reset carries `out_freq` = 0.
- R6: An input of I = 0 and Q = 0 gives exactly `out_mag` = 0 and `out_phase` = 0.
- R7: Each sample accepted with `in_valid` high produces exactly one `out_valid` pulse, 19 clock edges later, with order preserved. Cycles without `in_valid` produce no output and do not change the angle that the next frequency is measured from.
- R8: While `rst_n` is low, `out_valid`, `out_mag`, `out_phase` and `out_freq` are all zero. Samples that are in flight when reset is asserted are discarded.
- R9: Full-scale inputs such as (−32768, −32768) do not overflow. They give `out_mag` = 46341 ±4 and `out_phase` = 40960 ±8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair qualifier |
| in_i | input | 16 | Signed in-phase sample |
| in_q | input | 16 | Signed quadrature sample |
| out_valid | output | 1 | Output word qualifier |
| out_mag | output | 16 | Unsigned vector length |
| out_phase | output | 16 | Binary angle, full scale one turn |
| out_freq | output | 16 | Angle change since the previous valid sample, modulo one turn |

## Verification
The assertions check several behaviours on every cycle. They keep the count of accepted-but-undelivered samples at or below the pipeline depth, and they forbid an output pulse with nothing in flight. They require the frequency word to equal the modular difference of successive output angles, with zero for the first output after reset, and they require quiet outputs during reset. The bench scenarios are the only way to show numerical accuracy. Those scenarios cover the length and angle on each axis and in each quadrant, full-scale corners, the zero vector, and rotating phasors in both directions that wrap the angle. The scenarios also cover the exact 19-edge latency, gaps in the input strobe, and the discarding of in-flight samples by a reset in mid-stream.

// File: rtl/iqpd_pkg.sv
package iqpd_pkg;

    // internal angle resolution: 2**ANG_W units per turn
    localparam int ANG_W = 24;

    // arctan(2**-k) expressed in 2**-24 turns; zero beyond the table
    function automatic logic [ANG_W-1:0] atan_step(input int k);
        case (k)
            0:       return 24'd2097152;
            1:       return 24'd1238021;
            2:       return 24'd654136;
            3:       return 24'd332050;
            4:       return 24'd166669;
            5:       return 24'd83416;
            6:       return 24'd41718;
            7:       return 24'd20860;
            8:       return 24'd10430;
            9:       return 24'd5215;
            10:      return 24'd2608;
            11:      return 24'd1304;
            12:      return 24'd652;
            13:      return 24'd326;
            14:      return 24'd163;
            15:      return 24'd81;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/iqpd_prerot.sv
module iqpd_prerot #(
    parameter int IN_W = 16,
    parameter int FRAC = 6,
    parameter int XW   = IN_W + FRAC + 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic signed [IN_W-1:0]        in_i,
    input  logic signed [IN_W-1:0]        in_q,
    output logic signed [XW-1:0]          x_o,
    output logic signed [XW-1:0]          y_o,
    output logic [iqpd_pkg::ANG_W-1:0]    z_o
);
    localparam int AW = iqpd_pkg::ANG_W;
    localparam logic [AW-1:0] HALF_TURN = {1'b1, {(AW-1){1'b0}}};

    logic signed [XW-1:0] xe, ye;

    always_comb begin
        xe = {{(XW-IN_W-FRAC){in_i[IN_W-1]}}, in_i, {FRAC{1'b0}}};
        ye = {{(XW-IN_W-FRAC){in_q[IN_W-1]}}, in_q, {FRAC{1'b0}}};
    end

    // left half plane: rotate by a half turn and preload the angle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else if (in_i[IN_W-1]) begin
            x_o <= -xe;
            y_o <= -ye;
            z_o <= HALF_TURN;
        end else begin
            x_o <= xe;
            y_o <= ye;
            z_o <= '0;
        end
    end
endmodule

// File: rtl/iqpd_cordic_stage.sv
module iqpd_cordic_stage #(
    parameter int XW    = 25,
    parameter int SHIFT = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic signed [XW-1:0]          x_i,
    input  logic signed [XW-1:0]          y_i,
    input  logic [iqpd_pkg::ANG_W-1:0]    z_i,
    output logic signed [XW-1:0]          x_o,
    output logic signed [XW-1:0]          y_o,
    output logic [iqpd_pkg::ANG_W-1:0]    z_o
);
    localparam logic [iqpd_pkg::ANG_W-1:0] STEP = iqpd_pkg::atan_step(SHIFT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else if (!y_i[XW-1]) begin
            x_o <= x_i + (y_i >>> SHIFT);
            y_o <= y_i - (x_i >>> SHIFT);
            z_o <= z_i + STEP;
        end else begin
            x_o <= x_i - (y_i >>> SHIFT);
            y_o <= y_i + (x_i >>> SHIFT);
            z_o <= z_i - STEP;
        end
    end
endmodule

// File: rtl/iqpd_post.sv
module iqpd_post #(
    parameter int XW    = 25,
    parameter int FRAC  = 6,
    parameter int MAG_W = 16,
    parameter int PH_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          g_vld,
    input  logic signed [XW-1:0]          x_i,
    input  logic signed [XW-1:0]          y_i,
    input  logic [iqpd_pkg::ANG_W-1:0]    z_i,
    output logic [MAG_W-1:0]              mag_o,
    output logic [PH_W-1:0]               ph_o,
    output logic [PH_W-1:0]               fr_o
);
    localparam int AW = iqpd_pkg::ANG_W;
    localparam int PW = XW + 16;
    localparam int SH = 16 + FRAC;
    localparam logic [15:0] K_INV = 16'd39797;   // 1/CORDIC gain, Q0.16

    typedef enum logic {DS_NOPREV, DS_PRIMED} ds_t;

    ds_t state_q, state_d;

    logic [PW-1:0]    prod, mag_full;
    logic [AW-1:0]    ph_full;
    logic [PH_W-1:0]  ph_rnd;
    logic [MAG_W-1:0] mag_sat;
    logic             is_zero;
    logic [MAG_W-1:0] mag_a;
    logic [PH_W-1:0]  ph_a;

    always_comb begin
        is_zero  = (x_i == '0) && (y_i == '0);
        prod     = {16'b0, x_i} * {{XW{1'b0}}, K_INV};
        mag_full = (prod + (PW'(1) << (SH-1))) >> SH;
        mag_sat  = (|(mag_full >> MAG_W)) ? '1 : MAG_W'(mag_full);
        ph_full  = z_i + (AW'(1) << (AW-PH_W-1));
        ph_rnd   = PH_W'(ph_full >> (AW-PH_W));
    end

    // gain correction and angle rounding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mag_a <= '0;
            ph_a  <= '0;
        end else begin
            mag_a <= is_zero ? '0 : mag_sat;
            ph_a  <= is_zero ? '0 : ph_rnd;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_NOPREV;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_NOPREV: if (g_vld) state_d = DS_PRIMED;
            DS_PRIMED: state_d = DS_PRIMED;
        endcase
    end

    // outputs: ph_o doubles as the previous angle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mag_o <= '0;
            ph_o  <= '0;
            fr_o  <= '0;
        end else if (g_vld) begin
            mag_o <= mag_a;
            ph_o  <= ph_a;
            unique case (state_q)
                DS_NOPREV: fr_o <= '0;
                DS_PRIMED: fr_o <= ph_a - ph_o;
            endcase
        end
    end
endmodule

// File: rtl/iq_polar_disc.sv
module iq_polar_disc #(
    parameter int IN_W   = 16,
    parameter int OUT_W  = 16,
    parameter int STAGES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_i,
    input  logic signed [IN_W-1:0] in_q,
    output logic                   out_valid,
    output logic [OUT_W-1:0]       out_mag,
    output logic [OUT_W-1:0]       out_phase,
    output logic [OUT_W-1:0]       out_freq
);
    localparam int FRAC = 6;
    localparam int XW   = IN_W + FRAC + 3;
    localparam int LAT  = STAGES + 3;
    localparam int AW   = iqpd_pkg::ANG_W;

    logic signed [XW-1:0] x_p [STAGES+1];
    logic signed [XW-1:0] y_p [STAGES+1];
    logic [AW-1:0]        z_p [STAGES+1];
    logic [LAT-1:0]       vld_sr;

    iqpd_prerot #(.IN_W(IN_W), .FRAC(FRAC), .XW(XW)) u_pre (
        .clk(clk), .rst_n(rst_n), .in_i(in_i), .in_q(in_q),
        .x_o(x_p[0]), .y_o(y_p[0]), .z_o(z_p[0])
    );

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        iqpd_cordic_stage #(.XW(XW), .SHIFT(s)) u_stg (
            .clk(clk), .rst_n(rst_n),
            .x_i(x_p[s]),   .y_i(y_p[s]),   .z_i(z_p[s]),
            .x_o(x_p[s+1]), .y_o(y_p[s+1]), .z_o(z_p[s+1])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_sr <= '0;
        else        vld_sr <= {vld_sr[LAT-2:0], in_valid};
    end

    iqpd_post #(.XW(XW), .FRAC(FRAC), .MAG_W(OUT_W), .PH_W(OUT_W)) u_post (
        .clk(clk), .rst_n(rst_n), .g_vld(vld_sr[LAT-2]),
        .x_i(x_p[STAGES]), .y_i(y_p[STAGES]), .z_i(z_p[STAGES]),
        .mag_o(out_mag), .ph_o(out_phase), .fr_o(out_freq)
    );

    assign out_valid = vld_sr[LAT-1];
endmodule

// File: rtl/iq_polar_disc_chk.sv
module iq_polar_disc_chk #(
    parameter int STAGES = 16,
    parameter int OUT_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_phase,
    input logic [OUT_W-1:0] out_freq
);
    localparam int LAT = STAGES + 3;
    localparam int CW  = $clog2(LAT + 2) + 1;

    logic [CW-1:0]    pend;
    logic             seen;
    logic [OUT_W-1:0] last_ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend    <= '0;
            seen    <= 1'b0;
            last_ph <= '0;
        end else begin
            pend <= pend + CW'(in_valid) - CW'(out_valid);
            if (out_valid) begin
                seen    <= 1'b1;
                last_ph <= out_phase;
            end
        end
    end

    // R7
    inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= CW'(LAT));

    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pend != '0);

    // R5
    first_freq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !seen) |-> out_freq == '0);

    // R4
    freq_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen) |-> out_freq == OUT_W'(out_phase - last_ph));

    // R8
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!out_valid && out_freq == '0 && out_phase == '0);
        end
    end
endmodule

bind iq_polar_disc iq_polar_disc_chk #(.STAGES(STAGES), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_phase(out_phase), .out_freq(out_freq)
);

// File: tb/tb_iq_polar_disc.sv
`timescale 1ns/1ps
module tb_iq_polar_disc;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic               out_valid;
    logic [15:0]        out_mag, out_phase, out_freq;

    always #10 clk = ~clk;

    iq_polar_disc dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_mag(out_mag), .out_phase(out_phase), .out_freq(out_freq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int wr = 0, rd = 0;
    int q_mag [1024];
    int q_ph  [1024];
    string q_mt [1024];
    string q_pt [1024];
    bit mon_first = 1;
    int mon_last_ph = 0, mon_last_exp = 0;

    // {I, Q, expected magnitude, expected angle}
    localparam int NV = 10;
    localparam int TV [NV][4] = '{
        '{  1000,      0,  1000,     0},
        '{     0,   1000,  1000, 16384},
        '{ -1000,      0,  1000, 32768},
        '{     0,  -1000,  1000, 49152},
        '{  3000,   4000,  5000,  9672},
        '{ -3000,   4000,  5000, 23096},
        '{ -3000,  -4000,  5000, 42440},
        '{  3000,  -4000,  5000, 55864},
        '{ 32767,  32767, 46340,  8192},
        '{-32768, -32768, 46341, 40960}
    };
    localparam string TAGS [NV] = '{"R2","R2","R3","R2","R2","R3","R3","R2","R9","R9"};

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int wrapd(input int a, input int b);
        int d;
        d = (a - b) & 65535;
        if (d > 32767) d -= 65536;
        return d;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int exp_ph(input int i, input int q);
        real a;
        if (i == 0 && q == 0) return 0;
        a = $atan2(real'(q), real'(i)) / (2.0 * 3.14159265358979) * 65536.0;
        return int'($floor(a + 0.5)) & 65535;
    endfunction

    function automatic int exp_mag(input int i, input int q);
        return int'($floor($sqrt(real'(i) * i + real'(q) * q) + 0.5));
    endfunction

    task automatic send(input int i, input int q, input int em, input int ep,
                        input string mt, input string pt);
        @(negedge clk);
        in_valid = 1'b1;
        in_i = 16'(i);
        in_q = 16'(q);
        q_mag[wr] = em; q_ph[wr] = ep; q_mt[wr] = mt; q_pt[wr] = pt;
        wr++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        wr = 0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
        chk(out_mag == 0 && out_phase == 0 && out_freq == 0, "R8", "outputs in reset",
            int'(out_mag) + int'(out_phase) + int'(out_freq), 0);
        rst_n = 1'b1;
    endtask

    // output monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            rd = 0;
            mon_first = 1;
        end else if (out_valid) begin
            if (rd >= wr) begin
                chk(1'b0, "R7", "output without pending sample", rd, wr);
            end else begin
                if (q_mt[rd] == "R6")
                    chk(out_mag == 0, "R6", "magnitude", int'(out_mag), 0);
                else
                    chk(iabs(int'(out_mag) - q_mag[rd]) <= 4, q_mt[rd], "magnitude",
                        int'(out_mag), q_mag[rd]);
                chk(iabs(wrapd(int'(out_phase), q_ph[rd])) <= ((q_pt[rd] == "R6") ? 0 : 8),
                    q_pt[rd], "phase", int'(out_phase), q_ph[rd]);
                if (mon_first) begin
                    chk(out_freq == 0, "R5", "first frequency", int'(out_freq), 0);
                end else begin
                    chk(int'(out_freq) == ((int'(out_phase) - mon_last_ph) & 65535), "R4",
                        "frequency exact", int'(out_freq), (int'(out_phase) - mon_last_ph) & 65535);
                    chk(iabs(wrapd(int'(out_freq), (q_ph[rd] - mon_last_exp) & 65535)) <= 16, "R4",
                        "frequency value", int'(out_freq), (q_ph[rd] - mon_last_exp) & 65535);
                end
                mon_first = 0;
                mon_last_ph = int'(out_phase);
                mon_last_exp = q_ph[rd];
                rd++;
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt;
        // R8 reset state
        do_reset();

        // table walk, back to back; first output checks R5
        for (int v = 0; v < NV; v++)
            send(TV[v][0], TV[v][1], TV[v][2], TV[v][3],
                 (TAGS[v] == "R9") ? "R9" : "R1", TAGS[v]);
        idle(25);

        // R7 latency of a lone sample
        send(2000, -1500, exp_mag(2000, -1500), exp_ph(2000, -1500), "R1", "R2");
        cnt = 0;
        do begin
            @(negedge clk);
            if (cnt == 0) in_valid = 1'b0;
            cnt++;
        end while (!out_valid && cnt < 100);
        chk(cnt == 19, "R7", "latency in edges", cnt, 19);
        idle(25);

        // R6 zero vector, then R7 gaps between samples
        send(0, 0, 0, 0, "R6", "R6");
        idle(3);
        send(-700, 900, exp_mag(-700, 900), exp_ph(-700, 900), "R1", "R3");
        idle(5);
        send(500, -20000, exp_mag(500, -20000), exp_ph(500, -20000), "R1", "R2");
        idle(25);

        // rotating phasors, both directions, wrapping the angle (R4)
        for (int dir = 0; dir < 2; dir++) begin
            for (int k = 0; k < 40; k++) begin
                real th;
                int ii, qq;
                th = 2.0 * 3.14159265358979 * real'(((dir == 0) ? 3000 : -7000) * k) / 65536.0;
                ii = int'($floor(20000.0 * $cos(th) + 0.5));
                qq = int'($floor(20000.0 * $sin(th) + 0.5));
                send(ii, qq, exp_mag(ii, qq), exp_ph(ii, qq), "R1", (ii < 0) ? "R3" : "R2");
            end
            idle(25);
        end

        // R9 other full-scale corners
        send(32767, -32768, exp_mag(32767, -32768), exp_ph(32767, -32768), "R9", "R9");
        send(-32768, 0, 32768, 32768, "R9", "R9");
        idle(25);
        chk(rd == wr, "R7", "every sample delivered", rd, wr);

        // R8 reset in mid-stream discards in-flight samples
        send(1000, 1000, 1414, 8192, "R1", "R2");
        send(-1000, 1000, 1414, 24576, "R1", "R3");
        do_reset();
        cnt = 0;
        for (int k = 0; k < 25; k++) begin
            @(negedge clk);
            if (out_valid) cnt++;
        end
        chk(cnt == 0, "R8", "outputs after flush", cnt, 0);
        // R5 first sample after reset
        send(-5000, -100, exp_mag(-5000, -100), exp_ph(-5000, -100), "R1", "R3");
        send(100, 5000, exp_mag(100, 5000), exp_ph(100, 5000), "R1", "R2");
        idle(25);
        chk(rd == wr, "R7", "every sample delivered after reset", rd, wr);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule